// File: doc/BRIEF.md
# Pipelined Six-Bit Floating-Point Adder

This block adds two non-negative numbers held in a compact six-bit floating-point word. The upper four bits of a word are an unsigned mantissa and the lower two bits are a two's-complement power-of-two exponent, so a word stands for mantissa × 2^exponent. The format is unnormalized: any mantissa, including zero, is legal with any exponent.

The sum is formed in four registered stages. The first stage measures how far the first exponent sits above the second. The second stage brings the first operand down to the second exponent by shifting its mantissa left. The third stage adds the two mantissas into a five-bit sum. The fourth stage folds a carry back into four bits by shifting right once and raising the exponent. A new operand pair can enter on every clock, and a valid flag travels with each pair.

The caller guarantees two things. The second exponent is never above the first. The left shift of the first mantissa never pushes a one out of the top. Exponent overflow during normalization wraps silently. Rounding, signs and special values are not part of the block.

Top module: `fp6_pipe_adder`

## Requirements
- R1: While `rst` is high, and on every clock after it falls until the first accepted pair reaches the end of the pipe, `out_valid` is 0.
- R2: A word is laid out as mantissa in bits [5:2] (unsigned) and exponent in bits [1:0] (two's complement, -2 to 1). Adding 010111 and 001110 gives 110110.
- R3: A pair sampled with `in_valid` high at a rising edge produces its result, with `out_valid` high, after the third rising edge that follows it, so the result is visible four edges after sampling.
- R4: When both exponents are equal, the result mantissa is the plain sum of the mantissas and the exponent is unchanged, provided that sum is below 16.
- R5: When the first exponent exceeds the second by d (0 to 3), the first mantissa is shifted left by d before the addition and the result carries the second exponent (when there is no carry). The caller keeps the shifted mantissa within four bits.
- R6: When the five-bit mantissa sum has bit 4 set, the result mantissa is sum bits [4:1] and the result exponent is the second exponent plus one, wrapping modulo 4 (01 becomes 10).
- R7: Pairs presented on consecutive clocks all produce results on consecutive clocks, in order, with no stall.
- R8: The caller only presents pairs whose second exponent, read as signed, is not above the first.
- R9: A clock with `in_valid` low produces a clock with `out_valid` low at the matching position in the output stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The operand pair on `in_a` and `in_b` is to be added |
| in_a | input | 6 | First addend, the one with the larger or equal exponent |
| in_b | input | 6 | Second addend |
| out_valid | output | 1 | `out_sum` holds a result |
| out_sum | output | 6 | Sum word, same layout as the operands |

## Verification
The assertions watch, on every clock, that the valid flag emerges exactly four edges after it entered and stays low through reset and the pipe's fill, that every result exponent is either the second operand's exponent or one above it, and that a raised exponent always comes with a mantissa whose top bit is set; they also flag callers who break the exponent-order or the shift-fit guarantee. Whether the mantissa value itself is right, including the worked example, the three-place alignment, the exponent wrap from 01 to 10 and the ordering of back-to-back results, can only be shown by the bench comparing each output against its own arithmetic model.

// File: rtl/fp6_pkg.sv
package fp6_pkg;

    localparam int MAN_W   = 4;
    localparam int EXP_W   = 2;
    localparam int WORD_W  = MAN_W + EXP_W;
    localparam int SUM_W   = MAN_W + 1;
    localparam int SHIFT_N = 1 << EXP_W;

    typedef logic [MAN_W-1:0] man_t;
    typedef logic [EXP_W-1:0] exp_t;
    typedef logic [SUM_W-1:0] sum_t;

    // Operand word: mantissa in the upper bits, exponent in the lower bits.
    typedef struct packed {
        man_t man;
        exp_t exp;
    } fp_t;

    // After the exponent comparison.
    typedef struct packed {
        logic valid;
        man_t man_a;
        man_t man_b;
        exp_t exp_b;
        exp_t shamt;
    } cmp_st_t;

    // After alignment: both mantissas share exp.
    typedef struct packed {
        logic valid;
        man_t man_a;
        man_t man_b;
        exp_t exp;
    } aln_st_t;

    // After the mantissa addition.
    typedef struct packed {
        logic valid;
        sum_t sum;
        exp_t exp;
    } add_st_t;

    // Final normalized result.
    typedef struct packed {
        logic valid;
        fp_t  res;
    } out_st_t;

    // Signed distance from lo up to hi; the caller keeps it non-negative.
    function automatic exp_t exp_gap(exp_t hi, exp_t lo);
        logic signed [EXP_W:0] d;
        d = $signed({hi[EXP_W-1], hi}) - $signed({lo[EXP_W-1], lo});
        return exp_t'(d);
    endfunction

endpackage

// File: rtl/fp6_stage_cmp.sv
module fp6_stage_cmp
    import fp6_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    valid_i,
    input  fp_t     a_i,
    input  fp_t     b_i,
    output cmp_st_t st_o
);

    cmp_st_t nxt;

    always_comb begin
        nxt.valid = valid_i;
        nxt.man_a = a_i.man;
        nxt.man_b = b_i.man;
        nxt.exp_b = b_i.exp;
        nxt.shamt = exp_gap(a_i.exp, b_i.exp);
    end

    always_ff @(posedge clk) begin
        if (rst) st_o <= '0;
        else     st_o <= nxt;
    end

endmodule

// File: rtl/fp6_stage_align.sv
module fp6_stage_align
    import fp6_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  cmp_st_t st_i,
    output aln_st_t st_o
);

    // One wire-shifted copy of the first mantissa per possible distance.
    man_t cand [SHIFT_N];

    for (genvar k = 0; k < SHIFT_N; k++) begin : g_cand
        if (k == 0) begin : g_zero
            assign cand[k] = st_i.man_a;
        end else if (k >= MAN_W) begin : g_flush
            assign cand[k] = '0;
        end else begin : g_wire
            assign cand[k] = {st_i.man_a[MAN_W-1-k:0], {k{1'b0}}};
        end
    end

    aln_st_t nxt;

    always_comb begin
        nxt.valid = st_i.valid;
        nxt.man_a = cand[st_i.shamt];
        nxt.man_b = st_i.man_b;
        nxt.exp   = st_i.exp_b;
    end

    always_ff @(posedge clk) begin
        if (rst) st_o <= '0;
        else     st_o <= nxt;
    end

endmodule

// File: rtl/fp6_stage_add.sv
module fp6_stage_add
    import fp6_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  aln_st_t st_i,
    output add_st_t st_o
);

    add_st_t nxt;

    always_comb begin
        nxt.valid = st_i.valid;
        nxt.sum   = {1'b0, st_i.man_a} + {1'b0, st_i.man_b};
        nxt.exp   = st_i.exp;
    end

    always_ff @(posedge clk) begin
        if (rst) st_o <= '0;
        else     st_o <= nxt;
    end

endmodule

// File: rtl/fp6_stage_norm.sv
module fp6_stage_norm
    import fp6_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  add_st_t st_i,
    output out_st_t st_o
);

    out_st_t nxt;
    logic    carry;

    assign carry = st_i.sum[SUM_W-1];

    always_comb begin
        nxt.valid = st_i.valid;
        if (carry) begin
            nxt.res.man = st_i.sum[SUM_W-1:1];
            nxt.res.exp = st_i.exp + exp_t'(1);
        end else begin
            nxt.res.man = st_i.sum[MAN_W-1:0];
            nxt.res.exp = st_i.exp;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_o <= '0;
        else     st_o <= nxt;
    end

endmodule

// File: rtl/fp6_pipe_adder.sv
module fp6_pipe_adder
    import fp6_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_a,
    input  logic [WORD_W-1:0] in_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_sum
);

    cmp_st_t s_cmp;
    aln_st_t s_aln;
    add_st_t s_add;
    out_st_t s_out;

    fp6_stage_cmp u_cmp (
        .clk     (clk),
        .rst     (rst),
        .valid_i (in_valid),
        .a_i     (fp_t'(in_a)),
        .b_i     (fp_t'(in_b)),
        .st_o    (s_cmp)
    );

    fp6_stage_align u_aln (
        .clk  (clk),
        .rst  (rst),
        .st_i (s_cmp),
        .st_o (s_aln)
    );

    fp6_stage_add u_add (
        .clk  (clk),
        .rst  (rst),
        .st_i (s_aln),
        .st_o (s_add)
    );

    fp6_stage_norm u_norm (
        .clk  (clk),
        .rst  (rst),
        .st_i (s_add),
        .st_o (s_out)
    );

    assign out_valid = s_out.valid;
    assign out_sum   = s_out.res;

endmodule

// File: rtl/fp6_pipe_adder_chk.sv
module fp6_pipe_adder_chk
    import fp6_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_a,
    input logic [WORD_W-1:0] in_b,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_sum
);

    localparam int DEPTH = 4;

    // Clocks since reset fell, saturating once the pipe is full.
    logic [2:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                   since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    logic full;
    assign full = (since_rst >= 3'(DEPTH));

    logic [MAN_W+SHIFT_N-1:0] wide_shift;
    assign wide_shift = {{SHIFT_N{1'b0}}, in_a[WORD_W-1:EXP_W]} << exp_gap(in_a[EXP_W-1:0], in_b[EXP_W-1:0]);

    AST_RESET_QUIET: assert property (@(posedge clk) (rst || !full) |=> (rst || since_rst <= 3'(DEPTH)) ? !out_valid || full : 1'b1) // R1
        else $error("output valid before pipe filled");

    AST_FILL_QUIET: assert property (@(posedge clk) disable iff (rst) !full |-> !out_valid) // R1
        else $error("output valid during fill");

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst) (full && $past(in_valid, 4)) |-> out_valid) // R3
        else $error("result missing four edges after entry");

    AST_BUBBLE: assert property (@(posedge clk) disable iff (rst) (full && !$past(in_valid, 4)) |-> !out_valid) // R9
        else $error("spurious valid result");

    AST_EXP_RESULT: assert property (@(posedge clk) disable iff (rst)
        (full && out_valid) |-> (out_sum[EXP_W-1:0] == $past(in_b[EXP_W-1:0], 4)) ||
                                (out_sum[EXP_W-1:0] == exp_t'($past(in_b[EXP_W-1:0], 4) + exp_t'(1)))) // R5
        else $error("result exponent not derived from second operand");

    AST_CARRY_MSB: assert property (@(posedge clk) disable iff (rst)
        (full && out_valid && out_sum[EXP_W-1:0] != $past(in_b[EXP_W-1:0], 4)) |-> out_sum[WORD_W-1]) // R6
        else $error("raised exponent without top mantissa bit");

    AST_EXP_ORDER: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ($signed(in_a[EXP_W-1:0]) >= $signed(in_b[EXP_W-1:0]))) // R8
        else $error("second exponent above first");

    AST_ALIGN_FIT: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (wide_shift[MAN_W+SHIFT_N-1:MAN_W] == '0)) // R5
        else $error("alignment would lose mantissa bits");

endmodule

bind fp6_pipe_adder fp6_pipe_adder_chk u_chk (.*);

// File: tb/tb_fp6_pipe_adder.sv
module tb_fp6_pipe_adder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [5:0] in_a = '0;
    logic [5:0] in_b = '0;
    logic       out_valid;
    logic [5:0] out_sum;

    always #4 clk = ~clk; // 125 MHz

    fp6_pipe_adder dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_sum   (out_sum)
    );

    typedef struct {
        bit         v;
        logic [5:0] res;
        int         req;
    } expect_t;

    expect_t q[$];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Arithmetic model of the format: value = mantissa * 2^exponent.
    function automatic logic [5:0] model(logic [5:0] a, logic [5:0] b);
        int ea, eb, ma, mb, s, e;
        ea = $signed(a[1:0]);
        eb = $signed(b[1:0]);
        ma = int'(a[5:2]);
        mb = int'(b[5:2]);
        s  = ((ma << (ea - eb)) % 16) + mb;
        e  = eb;
        if (s >= 16) begin
            s = s / 2;
            e = e + 1;
        end
        return {4'(s), 2'(e)};
    endfunction

    function automatic logic [5:0] word(int m, int e);
        return {4'(m), 2'(e)};
    endfunction

    task automatic check_out();
        if (q.size() == 4) begin
            expect_t x;
            x = q.pop_front();
            n_tests++;
            if (out_valid !== x.v) begin
                n_fail++;
                $display("FAIL R%0d valid: got %b expected %b", x.req, out_valid, x.v);
            end else if (x.v && out_sum !== x.res) begin
                n_fail++;
                $display("FAIL R%0d sum: got %b expected %b", x.req, out_sum, x.res);
            end
        end else begin
            n_tests++; // R1: pipe still filling
            if (out_valid !== 1'b0) begin
                n_fail++;
                $display("FAIL R1 fill valid: got %b expected 0", out_valid);
            end
        end
    endtask

    task automatic step(bit v, logic [5:0] a, logic [5:0] b, int req);
        expect_t x;
        @(negedge clk);
        check_out();
        in_valid = v;
        in_a     = a;
        in_b     = b;
        x.v   = v;
        x.res = model(a, b);
        x.req = req;
        q.push_back(x);
    endtask

    task automatic rand_pair(output logic [5:0] a, output logic [5:0] b);
        int eb, ea, d, ma, mb;
        eb = int'($urandom_range(3)) - 2;
        ea = eb + int'($urandom_range(1 - eb));
        d  = ea - eb;
        ma = int'($urandom_range(15 >> d));
        mb = int'($urandom_range(15));
        a  = word(ma, ea);
        b  = word(mb, eb);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: quiet output during reset
        repeat (3) begin
            @(negedge clk);
            n_tests++;
            if (out_valid !== 1'b0) begin
                n_fail++;
                $display("FAIL R1 reset valid: got %b expected 0", out_valid);
            end
        end
        rst = 1'b0;

        // R2: worked example 010111 + 001110 = 110110
        step(1, 6'b010111, 6'b001110, 2);
        // R4: equal exponents 3 + 4 at exponent 0
        step(1, word(3, 0), word(4, 0), 4);
        // R5: widest alignment, 1*2^1 + 7*2^-2 -> 15*2^-2
        step(1, word(1, 1), word(7, -2), 5);
        // R5: distance one
        step(1, word(6, 0), word(2, -1), 5);
        // R6: carry, 15+15 at exponent 0 -> 15*2^1
        step(1, word(15, 0), word(15, 0), 6);
        // R6: exponent wraps from 01 to 10
        step(1, word(15, 1), word(1, 1), 6);
        // R9: bubble
        step(0, word(5, 0), word(5, 0), 9);
        // R4: zeros
        step(1, word(0, -2), word(0, -2), 4);
        step(0, '0, '0, 9);

        // R7: back-to-back random pairs
        for (int i = 0; i < 300; i++) begin
            logic [5:0] a, b;
            rand_pair(a, b);
            step(1, a, b, 7);
        end

        // R9: random pairs with bubbles
        for (int i = 0; i < 300; i++) begin
            logic [5:0] a, b;
            rand_pair(a, b);
            step(($urandom_range(4) != 0), a, b, 9);
        end

        // flush the pipe
        repeat (4) step(0, '0, '0, 9);
        @(negedge clk);
        check_out();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule